// File: doc/BRIEF.md
# Tone Pair Steering Validator

This block qualifies the early-steering signal from a dual-tone detector and decides when a detected key is real. It sits between the frequency detector and the rest of a tone receiver. The detector reports a 4-bit key code together with a level that is high while a valid frequency pair is heard. Two programmable cycle counters take the place of an external RC network. A tone counts only after the level has stayed high for a presence guard time. A registered tone is given up only after the level has stayed low for an absence guard time.

When a tone is accepted, the code on the input in that cycle is captured and the guard indication goes high. After a fixed settling delay of two cycles, the delayed-steering flag rises, the captured code moves into the visible receive register and a one-cycle new-data pulse fires. A burst that is too short changes nothing. A brief dropout inside an accepted tone is ridden through. The last accepted code stays visible until another tone is accepted.

Top module: `tone_steer_validator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rx_code` is 0 and `guard_active`, `steer_valid` and `rx_new` are low.
- R2: With `tone_present` sampled high on P consecutive rising edges (P = `pres_guard`), `guard_active` rises at the P-th of those edges, and the code captured is `tone_code` as sampled at that edge.
- R3: A high run of `tone_present` shorter than P leaves `guard_active`, `steer_valid`, `rx_new` and `rx_code` unchanged.
- R4: `steer_valid` rises exactly two edges after `guard_active` rises, and `rx_code` takes the captured code at that same edge and changes at no other time.
- R5: `rx_new` is high for exactly one cycle per accepted tone, in the first cycle that `steer_valid` is high.
- R6: Once `steer_valid` is high, A consecutive low samples of `tone_present` (A = `abs_guard`) make `guard_active` and `steer_valid` fall at the A-th edge, and `rx_code` keeps its value.
- R7: A dropout of fewer than A low samples inside an accepted tone keeps both flags high and raises no `rx_new`. The absence count restarts when the level returns high, so two short dropouts separated by one high cycle do not release the tone.
- R8: Changes on `tone_code` after the capture edge, and `tone_present` falling during the two settling cycles, do not alter the delayed data. Absence timing starts only once `steer_valid` is high.
- R9: A guard setting of 0 behaves as 1.
- R10: The presence count restarts whenever `tone_present` goes low, so split high runs that each fall short of P are rejected even if together they exceed P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_present | input | 1 | Early-steering level from the frequency detector |
| tone_code | input | CODE_W | Decoded key code from the detector |
| pres_guard | input | CNT_W | Presence guard time in cycles |
| abs_guard | input | CNT_W | Absence guard time in cycles |
| rx_code | output | CODE_W | Receive register holding the last accepted code |
| steer_valid | output | 1 | Delayed-steering flag |
| guard_active | output | 1 | Guard-time indication, high from acceptance to release |
| rx_new | output | 1 | One-cycle pulse when new data appears |

## Verification
The bench aims at the exact edge where each guard time expires. A design one count off would accept a burst of P-1 cycles or release one cycle early. Split bursts and dropouts separated by a single high cycle expose a counter that accumulates instead of restarting: it would accept noise, or drop a tone that is still present. The bench changes the key code right after the capture edge and drops the level during settling. A register that copies live input would then show the wrong key, and a controller that times absence too early would cut the settling short. Zero guard settings are checked to catch a counter that never expires.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int SETTLE_CYCLES = 2;
    localparam int SC_W          = $clog2(SETTLE_CYCLES + 1);

    typedef enum logic [1:0] {
        ST_WAIT_TONE = 2'd0,
        ST_SETTLE    = 2'd1,
        ST_HOLD      = 2'd2
    } steer_state_t;

    typedef struct packed {
        logic capture;
        logic commit;
        logic release_tone;
    } steer_evt_t;

    function automatic logic settle_last(input logic [SC_W-1:0] sc);
        return sc == SC_W'(SETTLE_CYCLES - 1);
    endfunction

endpackage

// File: rtl/tps_run_timer.sv
module tps_run_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             lvl,
    input  logic [CNT_W-1:0] target,
    output logic             reached
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] nxt;
    logic [EXT_W-1:0] tgt;

    assign nxt     = {1'b0, cnt_q} + EXT_W'(1);
    assign tgt     = (target == '0) ? EXT_W'(1) : {1'b0, target};
    assign reached = lvl && !clr && (nxt >= tgt);

    always_ff @(posedge clk) begin
        if (rst || clr || !lvl) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R7 / R10: a run restarts from zero once the timed level goes away
    assert_run_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (clr || !lvl) |=> (cnt_q == '0));

endmodule

// File: rtl/tps_steer_ctrl.sv
module tps_steer_ctrl
    import tps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic est,
    input  logic pres_hit,
    input  logic abs_hit,
    output logic pres_clr,
    output logic abs_clr,
    output logic capture,
    output logic commit,
    output logic gt,
    output logic ds
);
    steer_state_t    st_q;
    logic [SC_W-1:0] sc_q;
    logic            gt_q;
    logic            ds_q;
    steer_evt_t      evt;

    always_comb begin
        evt = '0;
        case (st_q)
            ST_WAIT_TONE: evt.capture      = est && pres_hit;
            ST_SETTLE:    evt.commit       = settle_last(sc_q);
            ST_HOLD:      evt.release_tone = abs_hit;
            default:      evt              = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_WAIT_TONE;
            sc_q <= '0;
            gt_q <= 1'b0;
            ds_q <= 1'b0;
        end else if (evt.capture) begin
            st_q <= ST_SETTLE;
            sc_q <= '0;
            gt_q <= 1'b1;
        end else if (st_q == ST_SETTLE) begin
            if (evt.commit) begin
                st_q <= ST_HOLD;
                ds_q <= 1'b1;
            end else begin
                sc_q <= sc_q + SC_W'(1);
            end
        end else if (evt.release_tone) begin
            st_q <= ST_WAIT_TONE;
            gt_q <= 1'b0;
            ds_q <= 1'b0;
        end
    end

    assign pres_clr = (st_q != ST_WAIT_TONE);
    assign abs_clr  = (st_q != ST_HOLD);
    assign capture  = evt.capture;
    assign commit   = evt.commit;
    assign gt       = gt_q;
    assign ds       = ds_q;

    assert_gt_needs_tone_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(gt_q) |-> $past(est));

    assert_gt_falls_in_silence_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(gt_q) |-> !$past(est));

    assert_ds_inside_guard_R4: assert property (@(posedge clk) disable iff (rst)
        ds_q |-> gt_q);

    assert_ds_after_settle_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ds_q) |-> $past(gt_q, 2));

endmodule

// File: rtl/tps_rx_reg.sv
module tps_rx_reg #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              commit,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] rx_code,
    output logic              rx_new
);
    logic [CODE_W-1:0] cap_q;
    logic [CODE_W-1:0] rx_q;
    logic              nd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            rx_q  <= '0;
            nd_q  <= 1'b0;
        end else begin
            if (capture) cap_q <= code_in;
            if (commit)  rx_q  <= cap_q;
            nd_q <= commit;
        end
    end

    assign rx_code = rx_q;
    assign rx_new  = nd_q;

    assert_rx_moves_with_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_q) |-> nd_q);

    assert_new_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        nd_q |=> !nd_q);

endmodule

// File: rtl/tone_steer_validator.sv
module tone_steer_validator #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tone_present,
    input  logic [CODE_W-1:0] tone_code,
    input  logic [CNT_W-1:0]  pres_guard,
    input  logic [CNT_W-1:0]  abs_guard,
    output logic [CODE_W-1:0] rx_code,
    output logic              steer_valid,
    output logic              guard_active,
    output logic              rx_new
);
    localparam int N_TIMERS = 2;  // index 0: presence, 1: absence

    logic [N_TIMERS-1:0] t_clr;
    logic [N_TIMERS-1:0] t_lvl;
    logic [N_TIMERS-1:0] t_hit;
    logic [CNT_W-1:0]    t_tgt [N_TIMERS];
    logic                capture;
    logic                commit;

    assign t_lvl[0] = tone_present;
    assign t_lvl[1] = !tone_present;
    assign t_tgt[0] = pres_guard;
    assign t_tgt[1] = abs_guard;

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_timer
        tps_run_timer #(.CNT_W(CNT_W)) u_timer (
            .clk     (clk),
            .rst     (rst),
            .clr     (t_clr[g]),
            .lvl     (t_lvl[g]),
            .target  (t_tgt[g]),
            .reached (t_hit[g])
        );
    end

    tps_steer_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .est      (tone_present),
        .pres_hit (t_hit[0]),
        .abs_hit  (t_hit[1]),
        .pres_clr (t_clr[0]),
        .abs_clr  (t_clr[1]),
        .capture  (capture),
        .commit   (commit),
        .gt       (guard_active),
        .ds       (steer_valid)
    );

    tps_rx_reg #(.CODE_W(CODE_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .commit  (commit),
        .code_in (tone_code),
        .rx_code (rx_code),
        .rx_new  (rx_new)
    );

endmodule

// File: tb/sim_tone_steer_validator.sv
`timescale 1ns/1ps
module sim_tone_steer_validator;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tone_present = 1'b0;
    logic [CODE_W-1:0] tone_code = '0;
    logic [CNT_W-1:0]  pres_guard = 16'd5;
    logic [CNT_W-1:0]  abs_guard = 16'd4;
    logic [CODE_W-1:0] rx_code;
    logic              steer_valid;
    logic              guard_active;
    logic              rx_new;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tone_steer_validator #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .tone_present(tone_present), .tone_code(tone_code),
        .pres_guard(pres_guard), .abs_guard(abs_guard), .rx_code(rx_code),
        .steer_valid(steer_valid), .guard_active(guard_active), .rx_new(rx_new)
    );

    // {code, high cycles, low cycles, accepted} with P=5, A=4
    localparam logic [15:0] VEC [7] = '{
        16'h1_3_8_0, 16'h2_5_9_1, 16'h3_4_8_0, 16'hA_7_8_1,
        16'hF_C_8_1, 16'h0_1_8_0, 16'hD_6_9_1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called right after a falling edge
    task automatic drive_tone(input logic [3:0] c, input int on, input int off, output int ndc);
        ndc = 0;
        tone_present = 1'b1;
        tone_code = c;
        repeat (on) begin @(negedge clk); ndc += int'(rx_new); end
        tone_present = 1'b0;
        repeat (off) begin @(negedge clk); ndc += int'(rx_new); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] last;
        int ndc;
        repeat (3) @(negedge clk);
        chk("R1 guard in reset", guard_active, 0);
        chk("R1 valid in reset", steer_valid, 0);
        chk("R1 code in reset", rx_code, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 new after reset", rx_new, 0);
        chk("R1 code after reset", rx_code, 0);

        // table walk: R2 R3 R6
        last = 4'h0;
        for (int v = 0; v < 7; v++) begin
            drive_tone(VEC[v][15:12], int'(VEC[v][11:8]), int'(VEC[v][7:4]), ndc);
            if (VEC[v][0]) last = VEC[v][15:12];
            chk($sformatf("R3/R5 pulses vec %0d", v), ndc, {31'd0, VEC[v][0]});
            chk($sformatf("R2/R3 code vec %0d", v), rx_code, last);
            chk($sformatf("R6 guard released vec %0d", v), guard_active, 0);
            chk($sformatf("R6 valid released vec %0d", v), steer_valid, 0);
        end

        // exact timing: R2 R4 R5 R8 (code change after capture)
        tone_present = 1'b1;
        tone_code = 4'h7;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == 4) chk("R2 guard before P", guard_active, 0);
            if (i == 5) begin
                chk("R2 guard at P", guard_active, 1);
                chk("R4 valid at P", steer_valid, 0);
                tone_code = 4'h9;
            end
            if (i == 6) begin
                chk("R4 valid at P+1", steer_valid, 0);
                chk("R4 code held at P+1", rx_code, 4'hD);
            end
            if (i == 7) begin
                chk("R4 valid at P+2", steer_valid, 1);
                chk("R8 code from capture edge", rx_code, 4'h7);
                chk("R5 pulse at P+2", rx_new, 1);
            end
            if (i == 8) chk("R5 pulse ends", rx_new, 0);
        end

        // dropouts shorter than A, split by one high cycle: R7
        ndc = 0;
        tone_present = 1'b0;
        repeat (3) begin @(negedge clk); ndc += int'(rx_new); end
        tone_present = 1'b1;
        @(negedge clk); ndc += int'(rx_new);
        tone_present = 1'b0;
        repeat (3) begin @(negedge clk); ndc += int'(rx_new); end
        tone_present = 1'b1;
        @(negedge clk); ndc += int'(rx_new);
        chk("R7 guard kept", guard_active, 1);
        chk("R7 valid kept", steer_valid, 1);
        chk("R7 no new pulse", ndc, 0);
        chk("R7 code kept", rx_code, 4'h7);

        // release after exactly A low samples: R6
        tone_present = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (i == 3) chk("R6 guard before A", guard_active, 1);
            if (i == 4) begin
                chk("R6 guard at A", guard_active, 0);
                chk("R6 valid at A", steer_valid, 0);
                chk("R6 code retained", rx_code, 4'h7);
            end
        end
        repeat (2) @(negedge clk);

        // split bursts: R10
        pres_guard = 16'd6;
        drive_tone(4'h4, 4, 1, ndc);
        chk("R10 first part no guard", guard_active, 0);
        drive_tone(4'h4, 4, 8, ndc);
        chk("R10 split rejected pulses", ndc, 0);
        chk("R10 split rejected code", rx_code, 4'h7);

        // level drops during settling: R8
        pres_guard = 16'd3;
        abs_guard = 16'd2;
        tone_present = 1'b1;
        tone_code = 4'h5;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == 3) begin chk("R8 guard at P", guard_active, 1); tone_present = 1'b0; end
            if (i == 5) begin
                chk("R8 valid despite drop", steer_valid, 1);
                chk("R8 code delivered", rx_code, 4'h5);
            end
            if (i == 6) chk("R8 guard held until absence", guard_active, 1);
            if (i == 7) chk("R8 released after A in hold", guard_active, 0);
        end

        // zero guard settings: R9
        pres_guard = 16'd0;
        abs_guard = 16'd0;
        tone_present = 1'b1;
        tone_code = 4'hB;
        @(negedge clk);
        chk("R9 guard after one sample", guard_active, 1);
        drive_tone(4'hB, 0, 6, ndc);
        chk("R9 one pulse", ndc, 1);
        chk("R9 code", rx_code, 4'hB);
        chk("R9 released", guard_active, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule